// File: doc/BRIEF.md
# Line-Sensor Frame Aligner and Pixel Unpacker

This block takes the byte stream of a swept linear thermal sensor and finds where each frame starts. The sensor sends 281 columns of 8 pixels as 1124 bytes. Each byte holds two 4-bit pixels. The last column is a marker column, not image data. Its first two bytes carry a fixed marker code, and its last two bytes carry status and temperature data.

While unlocked, the block hunts for two marker bytes in a row. It then checks that the marker pair comes back exactly one frame later. After that it declares lock. While locked, it splits every image byte into two pixels, odd row first, and tags each pixel with its column (1..280) and row (1..8). It copies the two status bytes into output registers. If the marker goes missing where it is expected, lock drops and an error pulse is raised.

The input is one byte per `byte_vld` strobe. Strobes arrive at least two clock cycles apart, since the sensor pixel clock is far slower than the system clock. The pixel stream, the lock flag and the status bytes feed downstream slice-assembly logic.

Top module: `slice_frame_sync`

## Requirements
- R1: A byte is a marker when bits 7:5 are 111 and bits 3:0 are 0000; bit 4 is ignored. While hunting, two consecutive accepted marker bytes are taken as the first two bytes of the marker column, and the next two accepted bytes are its status bytes.
- R2: After a marker pair is found, `locked` rises in the cycle after the marker pair is accepted again exactly 1124 bytes later. If the pair is not there, the block goes back to hunting and `locked` stays low.
- R3: No pixel is emitted (`pix_vld` stays low) unless the block is locked, including during the confirming frame.
- R4: While locked, each image byte gives two pixels: bits 7:4 in the cycle after the byte is accepted, then bits 3:0 in the next cycle.
- R5: Image byte k of a frame (k = 0..1119, counted from the byte after the fourth marker-column byte) is tagged column k/4+1. Its odd pixel is row 2*(k mod 4)+1 and its even pixel the row below it.
- R6: The third and fourth marker-column bytes are never emitted as pixels. They are copied to `stat0` and `stat1`, updated the cycle after each is accepted, whenever the block is confirming or locked.
- R7: While locked, a non-marker byte in the first or second marker-column position clears `locked` and raises `sync_err` for exactly one cycle, both in the cycle after that byte. The block then hunts again.
- R8: Under synchronous reset all outputs are zero and the block is hunting.
- R9: Cycles with `byte_vld` low do not advance the byte position, whatever `byte_in` holds.
- R10: `byte_vld` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Sensor byte: odd-row pixel in bits 7:4, even-row pixel in bits 3:0 |
| byte_vld | input | 1 | Byte strobe, at most every other cycle |
| pix_val | output | 4 | Pixel value |
| pix_col | output | 9 | Pixel column, 1..280 |
| pix_row | output | 4 | Pixel row, 1..8 |
| pix_vld | output | 1 | Pixel strobe |
| locked | output | 1 | Frame alignment held |
| stat0 | output | 8 | Last captured third marker-column byte |
| stat1 | output | 8 | Last captured fourth marker-column byte |
| sync_err | output | 1 | One-cycle pulse when the marker is lost |

## Verification
Every result is one register away from the byte that causes it:
- the odd pixel, `locked`, `sync_err` and the status registers appear in the cycle after the byte is accepted;
- the even pixel appears one cycle after the odd pixel.

The bench drives bytes on falling edges and reads outputs on the next falling edge. The lock and error checks come right after the byte that triggers them, before any idle cycles, so the one-cycle error pulse is caught. Pixels are matched in order against a queue of expected values that the bench fills as it drives each image byte. This catches any pixel sent while unlocked, in the wrong order, or with a wrong tag.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    SYNC_HUNT    = 2'd0,
    SYNC_CONFIRM = 2'd1,
    SYNC_TRACK   = 2'd2
  } sync_state_e;
endpackage

// File: rtl/sfs_marker_det.sv
// Recognises the marker byte and remembers whether the previous accepted byte was one.
module sfs_marker_det #(
  parameter int PIXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [PIXW-2:0] odd_hi,
  input  logic [PIXW-1:0] even_nib,
  output logic            hit,
  output logic            pair
);
  logic prev_hit_q;

  assign hit  = (&odd_hi) && (even_nib == '0);
  assign pair = vld && prev_hit_q && hit;

  always_ff @(posedge clk) begin
    if (rst)      prev_hit_q <= 1'b0;
    else if (vld) prev_hit_q <= hit;
  end
endmodule

// File: rtl/sfs_tracker.sv
// Hunt / confirm / track state machine with the frame position counters.
module sfs_tracker
  import sfs_pkg::*;
#(
  parameter int NCOL = 280,
  parameter int NROW = 8,
  localparam int BPC  = NROW / 2,
  localparam int COLW = $clog2(NCOL + 2),
  localparam int SUBW = (BPC > 1) ? $clog2(BPC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic            hit,
  input  logic            pair,
  output logic            locked,
  output logic            sync_err,
  output logic            pix_take,
  output logic            st3_take,
  output logic            st4_take,
  output logic [COLW-1:0] cur_col,
  output logic [SUBW-1:0] cur_sub
);
  localparam logic [COLW-1:0] MCOL    = COLW'(NCOL + 1);
  localparam logic [SUBW-1:0] SUB_END = SUBW'(BPC - 1);

  sync_state_e st_q, st_d;
  logic [COLW-1:0] col_q;
  logic [SUBW-1:0] sub_q;
  logic in_mark, mark_pos, aligned, lost;

  assign in_mark  = (col_q == MCOL);
  assign mark_pos = in_mark && (sub_q < SUBW'(2));
  assign aligned  = (st_q != SYNC_HUNT);
  assign lost     = vld && aligned && mark_pos && !hit;

  assign pix_take = vld && (st_q == SYNC_TRACK) && !in_mark;
  assign st3_take = vld && aligned && in_mark && (sub_q == SUBW'(2));
  assign st4_take = vld && aligned && in_mark && (sub_q == SUBW'(3));
  assign cur_col  = col_q;
  assign cur_sub  = sub_q;

  always_comb begin
    st_d = st_q;
    if (vld) begin
      unique case (st_q)
        SYNC_HUNT:    if (pair) st_d = SYNC_CONFIRM;
        SYNC_CONFIRM: if (lost) st_d = SYNC_HUNT;
                      else if (in_mark && sub_q == SUBW'(1)) st_d = SYNC_TRACK;
        SYNC_TRACK:   if (lost) st_d = SYNC_HUNT;
        default:      st_d = SYNC_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SYNC_HUNT;
      col_q    <= COLW'(1);
      sub_q    <= '0;
      locked   <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      st_q     <= st_d;
      locked   <= (st_d == SYNC_TRACK);
      sync_err <= lost && (st_q == SYNC_TRACK);
      if (vld) begin
        if (st_q == SYNC_HUNT) begin
          if (pair) begin
            col_q <= MCOL;
            sub_q <= SUBW'(2);
          end
        end else if (sub_q == SUB_END) begin
          sub_q <= '0;
          col_q <= in_mark ? COLW'(1) : col_q + COLW'(1);
        end else begin
          sub_q <= sub_q + SUBW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfs_unpack.sv
// Splits an image byte into two tagged pixels, odd row first.
module sfs_unpack #(
  parameter int NCOL = 280,
  parameter int NROW = 8,
  parameter int PIXW = 4,
  localparam int BPC  = NROW / 2,
  localparam int COLW = $clog2(NCOL + 2),
  localparam int SUBW = (BPC > 1) ? $clog2(BPC) : 1,
  localparam int ROWW = $clog2(NROW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [2*PIXW-1:0] byte_in,
  input  logic [COLW-1:0]   cur_col,
  input  logic [SUBW-1:0]   cur_sub,
  output logic [PIXW-1:0]   pix_val,
  output logic [COLW-1:0]   pix_col,
  output logic [ROWW-1:0]   pix_row,
  output logic              pix_vld
);
  logic            pend_q;
  logic [PIXW-1:0] even_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      even_q  <= '0;
      pix_val <= '0;
      pix_col <= '0;
      pix_row <= '0;
      pix_vld <= 1'b0;
    end else begin
      pix_vld <= take || pend_q;
      if (take) begin
        pix_val <= byte_in[2*PIXW-1:PIXW];
        even_q  <= byte_in[PIXW-1:0];
        pix_col <= cur_col;
        pix_row <= ROWW'({cur_sub, 1'b0}) + ROWW'(1);
        pend_q  <= 1'b1;
      end else if (pend_q) begin
        pix_val <= even_q;
        pix_row <= pix_row + ROWW'(1);
        pend_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfs_status.sv
// Holds the two status bytes of the marker column.
module sfs_status #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_a,
  input  logic          take_b,
  input  logic [BW-1:0] byte_in,
  output logic [BW-1:0] stat0,
  output logic [BW-1:0] stat1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat0 <= '0;
      stat1 <= '0;
    end else begin
      if (take_a) stat0 <= byte_in;
      if (take_b) stat1 <= byte_in;
    end
  end
endmodule

// File: rtl/slice_frame_sync.sv
module slice_frame_sync #(
  parameter int NCOL = 280,
  parameter int NROW = 8,
  parameter int PIXW = 4,
  localparam int BW   = 2 * PIXW,
  localparam int BPC  = NROW / 2,
  localparam int COLW = $clog2(NCOL + 2),
  localparam int SUBW = (BPC > 1) ? $clog2(BPC) : 1,
  localparam int ROWW = $clog2(NROW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   byte_in,
  input  logic            byte_vld,
  output logic [PIXW-1:0] pix_val,
  output logic [COLW-1:0] pix_col,
  output logic [ROWW-1:0] pix_row,
  output logic            pix_vld,
  output logic            locked,
  output logic [BW-1:0]   stat0,
  output logic [BW-1:0]   stat1,
  output logic            sync_err
);
  logic hit, pair, pix_take, st3_take, st4_take;
  logic [COLW-1:0] cur_col;
  logic [SUBW-1:0] cur_sub;

  sfs_marker_det #(.PIXW(PIXW)) u_det (
    .clk(clk), .rst(rst), .vld(byte_vld),
    .odd_hi(byte_in[BW-1:PIXW+1]), .even_nib(byte_in[PIXW-1:0]),
    .hit(hit), .pair(pair)
  );

  sfs_tracker #(.NCOL(NCOL), .NROW(NROW)) u_trk (
    .clk(clk), .rst(rst), .vld(byte_vld), .hit(hit), .pair(pair),
    .locked(locked), .sync_err(sync_err), .pix_take(pix_take),
    .st3_take(st3_take), .st4_take(st4_take),
    .cur_col(cur_col), .cur_sub(cur_sub)
  );

  sfs_unpack #(.NCOL(NCOL), .NROW(NROW), .PIXW(PIXW)) u_unp (
    .clk(clk), .rst(rst), .take(pix_take), .byte_in(byte_in),
    .cur_col(cur_col), .cur_sub(cur_sub),
    .pix_val(pix_val), .pix_col(pix_col), .pix_row(pix_row), .pix_vld(pix_vld)
  );

  sfs_status #(.BW(BW)) u_st (
    .clk(clk), .rst(rst), .take_a(st3_take), .take_b(st4_take),
    .byte_in(byte_in), .stat0(stat0), .stat1(stat1)
  );
endmodule

// File: rtl/slice_frame_sync_chk.sv
module slice_frame_sync_chk #(
  parameter int NCOL = 280,
  parameter int NROW = 8,
  parameter int PIXW = 4,
  localparam int BW   = 2 * PIXW,
  localparam int COLW = $clog2(NCOL + 2),
  localparam int ROWW = $clog2(NROW + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [BW-1:0]   byte_in,
  input logic            byte_vld,
  input logic [PIXW-1:0] pix_val,
  input logic [COLW-1:0] pix_col,
  input logic [ROWW-1:0] pix_row,
  input logic            pix_vld,
  input logic            locked,
  input logic [BW-1:0]   stat0,
  input logic [BW-1:0]   stat1,
  input logic            sync_err
);
  // R3
  no_pix_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> locked);

  // R4
  even_follows_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && pix_row[0]) |=> (pix_vld && pix_row == $past(pix_row) + ROWW'(1)
                                 && $stable(pix_col)));

  // R5
  tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> (pix_col >= COLW'(1) && pix_col <= COLW'(NCOL)
                 && pix_row >= ROWW'(1) && pix_row <= ROWW'(NROW)));

  // R2
  lock_rise_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> !pix_vld);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> (!locked && $past(locked)));

  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> !sync_err);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!locked && !pix_vld && !sync_err && stat0 == '0 && stat1 == '0));

  // R10
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_vld) |-> ($stable(stat0) && $stable(stat1)));

  logic unused_ok;
  assign unused_ok = ^{byte_in, pix_val};
endmodule

bind slice_frame_sync slice_frame_sync_chk #(.NCOL(NCOL), .NROW(NROW), .PIXW(PIXW)) u_chk (
  .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
  .pix_val(pix_val), .pix_col(pix_col), .pix_row(pix_row), .pix_vld(pix_vld),
  .locked(locked), .stat0(stat0), .stat1(stat1), .sync_err(sync_err)
);

// File: tb/test_slice_frame_sync.sv
module test_slice_frame_sync;
  localparam int NCOL = 280, NROW = 8, BPC = NROW / 2, PB = NCOL * BPC;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] byte_in;
  logic byte_vld;
  logic [3:0] pix_val;
  logic [8:0] pix_col;
  logic [3:0] pix_row;
  logic pix_vld, locked, sync_err;
  logic [7:0] stat0, stat1;

  int checks = 0, failures = 0, err_cycles = 0;
  bit done = 0;
  logic [16:0] expq[$];
  logic [7:0] d3, d4;

  always #5 clk = ~clk;

  slice_frame_sync i_slice_frame_sync (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .pix_val(pix_val), .pix_col(pix_col), .pix_row(pix_row), .pix_vld(pix_vld),
    .locked(locked), .stat0(stat0), .stat1(stat1), .sync_err(sync_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // random image byte that never looks like a marker (R1 encoding)
  function automatic logic [7:0] rand_pix();
    logic [7:0] b;
    b = 8'($urandom);
    if (b[7:5] == 3'b111 && b[3:0] == 4'h0) b[0] = 1'b1;
    return b;
  endfunction

  function automatic logic [8:0] exp_col(int k);
    return 9'(k / BPC + 1);
  endfunction

  function automatic logic [3:0] exp_row(int k);
    return 4'(2 * (k % BPC) + 1);
  endfunction

  // one strobe then at least one idle cycle (R10); idle cycles carry a marker-like
  // byte so that a design reading byte_in without byte_vld would break (R9)
  task automatic send_byte(input logic [7:0] b, input bit gap);
    @(negedge clk);
    byte_in = b; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; byte_in = 8'hE0;
    if (gap) repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic send_frame(input bit emit, input bit bad1,
                            output logic [7:0] s3, output logic [7:0] s4);
    logic [7:0] b;
    for (int k = 0; k < PB; k++) begin
      b = rand_pix();
      if (emit) begin
        expq.push_back({b[7:4], exp_col(k), exp_row(k)});
        expq.push_back({b[3:0], exp_col(k), exp_row(k) + 4'd1});
      end
      send_byte(b, 1'b1);
      if (k == 500) repeat (40) @(negedge clk);
    end
    if (bad1) begin
      send_byte(8'h10, 1'b0);
      chk("R7 locked after missing marker", int'(locked), 0);
      chk("R7 sync_err pulse", int'(sync_err), 1);
    end else begin
      send_byte({3'b111, 1'($urandom), 4'h0}, 1'b1);
    end
    send_byte({3'b111, 1'($urandom), 4'h0}, 1'b1);
    s3 = rand_pix();
    s4 = rand_pix();
    send_byte(s3, 1'b1);
    send_byte(s4, 1'b1);
  endtask

  // pixel monitor (R3 R4 R5)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sync_err) err_cycles++;
      if (pix_vld) begin
        if (expq.size() == 0) begin
          chk("R3 pixel while not expected", 1, 0);
        end else begin
          logic [16:0] e;
          e = expq.pop_front();
          chk("R4 pixel value", int'(pix_val), int'(e[16:13]));
          chk("R5 pixel column", int'(pix_col), int'(e[12:4]));
          chk("R5 pixel row", int'(pix_row), int'(e[3:0]));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    rst = 1'b1; byte_vld = 1'b0; byte_in = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8
    chk("R8 locked at reset", int'(locked), 0);
    chk("R8 pix_vld at reset", int'(pix_vld), 0);
    chk("R8 sync_err at reset", int'(sync_err), 0);
    chk("R8 stat0 at reset", int'(stat0), 0);
    chk("R8 stat1 at reset", int'(stat1), 0);

    for (int i = 0; i < 37; i++) send_byte(rand_pix(), 1'b1);
    send_frame(1'b0, 1'b0, d3, d4);        // R1 hunt finds marker pair
    chk("R2 not locked after first marker", int'(locked), 0);
    chk("R6 stat0 while confirming", int'(stat0), int'(d3));
    chk("R6 stat1 while confirming", int'(stat1), int'(d4));
    send_frame(1'b0, 1'b0, d3, d4);        // R3 confirming frame, no pixels
    chk("R2 locked after second marker", int'(locked), 1);
    send_frame(1'b1, 1'b0, d3, d4);
    send_frame(1'b1, 1'b0, d3, d4);
    chk("R6 stat0 while locked", int'(stat0), int'(d3));
    chk("R6 stat1 while locked", int'(stat1), int'(d4));
    chk("R2 lock held", int'(locked), 1);
    send_frame(1'b1, 1'b1, d3, d4);        // R7 marker missing
    chk("R7 unlocked after loss", int'(locked), 0);
    send_frame(1'b0, 1'b0, d3, d4);        // R1 re-acquire
    chk("R2 not locked after reacquire", int'(locked), 0);
    send_frame(1'b0, 1'b0, d3, d4);
    chk("R2 relocked", int'(locked), 1);
    send_frame(1'b1, 1'b0, d3, d4);
    // R9: idle cycles with a marker on the bus change nothing
    byte_in = 8'hF0;
    repeat (12) @(negedge clk);
    chk("R9 lock kept over idle", int'(locked), 1);
    chk("R9 stat0 kept over idle", int'(stat0), int'(d3));
    repeat (4) @(negedge clk);
    chk("R4 all expected pixels seen", expq.size(), 0);
    chk("R7 sync_err cycles", err_cycles, 1);
    summary();
  end
endmodule